// File: doc/BRIEF.md
# Cached shift-register address loader

This block places a 24-bit memory address on three external 8-bit serial-in, parallel-out shift registers. The three registers are the low, middle and high address bytes. They share one serial data line, and each one has its own clock strobe. A requester presents an address with a valid/ready handshake. An optional force flag can be presented with the address.

The registers have no usable clear, so the block keeps a shadow copy of the byte last shifted into each of them. Each lane also has a flag that says whether its shadow copy is known. When a request is accepted, the block compares each address byte with its shadow copy. It then shifts only the lanes whose byte changed, in the order low, middle, high, and signals completion with a one-cycle done pulse.

After reset every shadow is unknown, so the first request reloads all lanes. A forced request also reloads all lanes. When the address steps sequentially, the low lane is reloaded on every access and the middle lane once every 256 addresses. The high lane is reloaded once every 65536 addresses.

Top module: `addr_shift_loader`

## Requirements
- R1: While reset is asserted and right after it is released, req_ready_o is 1, done_o is 0 and all sclk_o bits are 0.
- R2: The first request accepted after reset shifts every lane. Each sclk_o bit pulses exactly 8 times, and afterwards each external register holds its address byte.
- R3: A lane whose new byte equals its shadow copy receives no clock pulse. A request for an unchanged address completes with no pulses at all.
- R4: Bits go out MSB first. sdata_o holds the value of each bit during the cycle before the rising edge of the strobe and during the cycle in which the strobe is high.
- R5: Each strobe pulse is high for exactly one cycle and is followed by at least one low cycle. At most one sclk_o bit is high at any time.
- R6: The lanes map as follows: sclk_o[0] carries address bits 7:0, sclk_o[1] carries bits 15:8 and sclk_o[2] carries bits 23:16. Within one request, the changed lanes are shifted in that index order, lowest first.
- R7: When force_i is 1 at acceptance, all three lanes are shifted whatever their shadow copies hold.
- R8: A request is accepted on a cycle with req_valid_i and req_ready_o both 1. req_ready_o is 0 from the next cycle until done_o pulses. done_o lasts one cycle, with req_ready_o at 1 in that cycle, and no strobe pulses while req_ready_o is 1.
- R9: When the address steps sequentially, a step that carries out of a byte also shifts the lane above. For example, 0x00FFFF to 0x010000 shifts all three lanes, while 0x0000FE to 0x0000FF shifts only the low lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Address request valid |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_addr_i | input | 24 | Requested address |
| force_i | input | 1 | Reload all lanes; sampled at acceptance |
| sdata_o | output | 1 | Shared serial data line |
| sclk_o | output | 3 | Per-lane strobes: bit 0 low, bit 1 middle, bit 2 high |
| done_o | output | 1 | One-cycle pulse when the request has been serviced |

## Verification
The bench builds the block with its default parameters: three lanes of eight bits. That setting puts carries across both byte boundaries within reach of short sequential walks, including the 0x00FFFF to 0x010000 step that touches all three lanes.

A bench model of the three external registers clocks in sdata_o on each strobe edge. From that model the bench checks the register contents, the pulse count per lane, the setup and hold of the data line, and the lane order against its own shadow copies. Random requests mostly change a random subset of lanes and sometimes carry the force flag, which exercises every mix of skipped and shifted lanes.

// File: rtl/addr_loader_pkg.sv
package addr_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_SHIFT,
    ST_DONE
  } ldr_state_e;
endpackage

// File: rtl/lane_cache.sv
module lane_cache #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int AW    = LANES * LANE_W,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    cmp_addr_i,
  output logic [LANES-1:0] changed_o,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_lane_i,
  input  logic [LANE_W-1:0] wr_data_i
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] shadow_q;
    logic              known_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        known_q  <= 1'b0;
      end else if (wr_en_i && wr_lane_i == IW'(g)) begin
        shadow_q <= wr_data_i;
        known_q  <= 1'b1;
      end
    end
    assign changed_o[g] = !known_q || (shadow_q != cmp_addr_i[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW    = (LANE_W > 1) ? $clog2(LANE_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IW-1:0]     lane_i,
  input  logic [LANE_W-1:0] data_i,
  output logic              sdata_o,
  output logic [LANES-1:0]  sclk_o,
  output logic              done_o
);
  logic [LANE_W-1:0] sh_q;
  logic [IW-1:0]     lane_q;
  logic [CW-1:0]     cnt_q;
  logic              active_q, high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      lane_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      high_q   <= 1'b0;
    end else if (start_i) begin
      sh_q     <= data_i;
      lane_q   <= lane_i;
      cnt_q    <= '0;
      active_q <= 1'b1;
      high_q   <= 1'b0;
    end else if (active_q) begin
      if (!high_q) begin
        high_q <= 1'b1;
      end else begin
        high_q <= 1'b0;
        if (cnt_q == CW'(LANE_W - 1)) begin
          active_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          sh_q  <= {sh_q[LANE_W-2:0], 1'b0};
        end
      end
    end
  end

  // setup cycle (strobe low) then high cycle, data held across both
  assign sdata_o = sh_q[LANE_W-1];
  assign sclk_o  = (active_q && high_q) ? (LANES'(1) << lane_q) : '0;
  assign done_o  = active_q && high_q && (cnt_q == CW'(LANE_W - 1));
endmodule

// File: rtl/addr_shift_loader.sv
module addr_shift_loader
  import addr_loader_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int AW    = LANES * LANE_W,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             force_i,
  output logic             sdata_o,
  output logic [LANES-1:0] sclk_o,
  output logic             done_o
);
  ldr_state_e        state_q;
  logic [AW-1:0]     addr_q;
  logic [LANES-1:0]  dirty_q, changed;
  logic [IW-1:0]     lane_q, pick;
  logic              sh_start, sh_done, wr_en;

  always_comb begin
    pick = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (dirty_q[i]) pick = IW'(i);
    end
  end

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign done_o      = (state_q == ST_DONE);
  assign sh_start    = (state_q == ST_PICK) && (dirty_q != '0);
  assign wr_en       = (state_q == ST_SHIFT) && sh_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      dirty_q <= '0;
      lane_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (req_valid_i) begin
            addr_q  <= req_addr_i;
            dirty_q <= changed | {LANES{force_i}};
            state_q <= ST_PICK;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_PICK: begin
          if (dirty_q == '0) begin
            state_q <= ST_DONE;
          end else begin
            lane_q  <= pick;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sh_done) begin
            dirty_q[lane_q] <= 1'b0;
            state_q         <= ST_PICK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  lane_cache #(.LANES(LANES), .LANE_W(LANE_W)) u_cache (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmp_addr_i (req_addr_i),
    .changed_o  (changed),
    .wr_en_i    (wr_en),
    .wr_lane_i  (lane_q),
    .wr_data_i  (addr_q[lane_q*LANE_W +: LANE_W])
  );

  lane_shifter #(.LANES(LANES), .LANE_W(LANE_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .lane_i  (pick),
    .data_i  (addr_q[pick*LANE_W +: LANE_W]),
    .sdata_o (sdata_o),
    .sclk_o  (sclk_o),
    .done_o  (sh_done)
  );
endmodule

// File: rtl/addr_shift_loader_chk.sv
module addr_shift_loader_chk #(
  parameter int LANES = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             sdata_o,
  input logic [LANES-1:0] sclk_o,
  input logic             done_o
);
  assert_strobe_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sclk_o));

  assert_strobe_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != '0) |=> (sclk_o == '0));

  assert_data_setup_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != '0) |-> $stable(sdata_o));

  assert_no_strobe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sclk_o == '0));

  assert_done_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind addr_shift_loader addr_shift_loader_chk #(.LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .sdata_o     (sdata_o),
  .sclk_o      (sclk_o),
  .done_o      (done_o)
);

// File: tb/addr_shift_loader_test.sv
`timescale 1ns/1ps
module addr_shift_loader_test;
  localparam int LANES = 3;
  localparam int LW    = 8;
  localparam int AW    = LANES * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, force_r = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ready, sdata, done;
  logic [LANES-1:0] sclk;

  always #5 clk = ~clk;

  addr_shift_loader #(.LANES(LANES), .LANE_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_addr_i(addr), .force_i(force_r), .sdata_o(sdata), .sclk_o(sclk),
    .done_o(done)
  );

  int checks = 0, fails = 0;
  logic [LW-1:0] model [LANES];
  int pulses [LANES];
  logic [LW-1:0] exp_val [LANES];
  logic exp_known [LANES];
  logic [LANES-1:0] prev_sclk = '0;
  logic prev_sdata = 1'b0;
  int last_lane = 0;
  bit timing_err = 0, order_err = 0, busy = 0, ready_err = 0;
  logic [AW-1:0] cur = '0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external register model and line monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (!$onehot0(sclk)) timing_err = 1;
      if (prev_sclk != '0 && sclk != '0) timing_err = 1;
      if (ready && sclk != '0) ready_err = 1;
      if (busy && ready && !done) ready_err = 1;
      for (int k = 0; k < LANES; k++) begin
        if (!prev_sclk[k] && sclk[k]) begin
          if (sdata !== prev_sdata) timing_err = 1;
          model[k] = {model[k][LW-2:0], sdata};
          pulses[k]++;
          if (k < last_lane) order_err = 1;
          last_lane = k;
        end
      end
    end
    prev_sclk  = sclk;
    prev_sdata = sdata;
  end

  function automatic bit lane_changes(logic [AW-1:0] a, int k, bit f);
    return f || !exp_known[k] || (exp_val[k] != a[k*LW +: LW]);
  endfunction

  task automatic do_req(logic [AW-1:0] a, bit f, string tag);
    bit chg [LANES];
    int wd;
    for (int k = 0; k < LANES; k++) begin
      chg[k] = lane_changes(a, k, f);
      pulses[k] = 0;
    end
    last_lane = 0; timing_err = 0; order_err = 0; ready_err = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    addr = a; force_r = f; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; force_r = 1'b0; busy = 1;
    wd = 0;
    while (!done && wd < 200) begin @(negedge clk); wd++; end
    busy = 0;
    check(wd < 200, {tag, " R8 done"}, wd, 0);
    check(!ready_err, {tag, " R8 ready"}, ready_err, 0);
    check(!timing_err, {tag, " R4 R5 timing"}, timing_err, 0);
    check(!order_err, {tag, " R6 order"}, order_err, 0);
    for (int k = 0; k < LANES; k++) begin
      check(pulses[k] == (chg[k] ? LW : 0), {tag, " R3 pulses"}, pulses[k], chg[k] ? LW : 0);
      check(model[k] == a[k*LW +: LW], {tag, " R2 R6 contents"}, model[k], a[k*LW +: LW]);
      exp_val[k] = a[k*LW +: LW];
      exp_known[k] = 1;
    end
    cur = a;
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < LANES; k++) begin
      model[k] = '0; pulses[k] = 0; exp_val[k] = '0; exp_known[k] = 0;
    end
    repeat (3) @(negedge clk);
    check(ready && !done && sclk == '0, "R1 in reset", {ready, done, sclk}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !done && sclk == '0, "R1 after reset", {ready, done, sclk}, 5'b10000);

    do_req(24'h000000, 0, "R2 first");
    do_req(24'h000000, 0, "R3 repeat");
    do_req(24'hA5C33C, 0, "R6 all");
    do_req(24'hA5C33D, 0, "R3 low only");
    do_req(24'hA5C33D, 1, "R7 force");
    do_req(24'h0000FE, 0, "R9 set");
    do_req(24'h0000FF, 0, "R9 step");
    do_req(24'h000100, 0, "R9 carry mid");
    do_req(24'h00FFFF, 0, "R9 set2");
    do_req(24'h010000, 0, "R9 carry high");
    do_req(24'h120000, 0, "R3 high only");

    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] a;
      a = cur;
      for (int k = 0; k < LANES; k++)
        if ($urandom_range(1, 0) == 1) a[k*LW +: LW] = LW'($urandom);
      do_req(a, ($urandom_range(7, 0) == 0), "R3 R7 random");
    end
    for (int n = 0; n < 10; n++) do_req(cur + 1, 0, "R9 walk");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule